// File: doc/BRIEF.md
# Pipeline Cell Address Controller

This block drives the addressing of a 144-cell circular analog sample store that captures one sample per bunch crossing while a first-level trigger decision is in flight. Every clock it moves a write pointer to the next cell that may be overwritten. When a trigger accept arrives, it reserves five consecutive cells. The first of them sits a programmed number of crossings behind the cell being written in that cycle. The event is placed in a queue, and the reserved cell addresses are later offered to the digitizer side one at a time.

Reserved cells are protected until the converter acknowledges them. The write pointer jumps over any cell still held, so the spare cells beyond the latency depth act as a buffer for several pending events. Events are served first-in first-out. Within an event, the oldest sample is served first. Addresses wrap modulo the cell count, including windows that straddle the wrap point.

Top module: `pipe_cell_addr_ctrl`

## Requirements
- R1: After reset, wr_en, rd_valid, busy, overflow and cfg_err are all 0. The first clock edge after reset release writes cell 0, with wr_en high.
- R2: When no reserved cell lies ahead, wr_addr advances by exactly one cell per clock, with wr_en high.
- R3: A trigger accepted in a cycle where wr_addr is W reserves cells (W - L + k) mod 144 for k = 0..4, where L is the programmed latency.
- R4: The write pointer never lands on a reserved cell. Cells reserved by a trigger in the current cycle are also skipped on the very next edge.
- R5: While an event is pending, rd_valid is high and rd_addr shows the oldest unacknowledged cell of the oldest event. A cycle with rd_valid and rd_req both high acknowledges that cell. Events are served in arrival order, and cells within an event in ascending time order.
- R6: An acknowledged cell is released from the edge of its acknowledgement, and the write pointer may use it again afterwards.
- R7: Up to 8 events may be pending. busy is high exactly while 8 are pending. A trigger while busy is rejected and produces no addresses.
- R8: All addresses lie in 0..143 and wrap modulo 144, including windows that cross cell 0.
- R9: A latency write (cfg_we) takes effect only when no event is pending and the value is in 1..100. Otherwise cfg_err is high in the following cycle and the latency is left unchanged.
- R10: If no free cell exists, then on the next edge overflow goes high, wr_en goes low and wr_addr holds its value, so the sample is dropped.
- R11: The latency after reset is 100 crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger accept, one cycle per event |
| cfg_we | input | 1 | Latency write strobe |
| cfg_lat | input | 7 | Latency value in crossings |
| rd_req | input | 1 | Converter acknowledges rd_addr this cycle |
| wr_addr | output | 8 | Cell written in this cycle |
| wr_en | output | 1 | Sample stored in wr_addr this cycle |
| overflow | output | 1 | No free cell; sample dropped |
| rd_valid | output | 1 | A reserved address is on offer |
| rd_addr | output | 8 | Cell address offered to the converter |
| busy | output | 1 | Event queue full |
| cfg_err | output | 1 | Previous latency write was refused |

## Verification
Wrong reservation state appears at the ports within one clock. wr_addr either fails to jump over a held window or skips a free cell. The fault shows on the edge after the trigger, or on the next lap of the pointer around the ring, which takes up to 144 cycles. Wrong queue or progress state shows as a wrong rd_addr or a missing or extra handshake as soon as the converter drains. The scoreboard compares every offered address with the window computed from the trigger-time wr_addr and the programmed latency. A latency register corrupted by a refused write shows in the addresses of the next accepted event.

// File: rtl/pca_pkg.sv
package pca_pkg;

  // Modular add for a < n, b <= n
  function automatic int idx_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Modular subtract for a < n, b <= n
  function automatic int idx_sub(input int a, input int b, input int n);
    int d;
    d = a - b;
    if (d < 0) d = d + n;
    return d;
  endfunction

endpackage

// File: rtl/pca_event_queue.sv
module pca_event_queue
  import pca_pkg::*;
#(
  parameter int NCELLS = 144,
  parameter int QDEPTH = 8,
  parameter int NSAMP  = 5,
  localparam int CW = $clog2(NCELLS),
  localparam int QW = $clog2(QDEPTH),
  localparam int NW = $clog2(QDEPTH + 1),
  localparam int SW = $clog2(NSAMP)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [CW-1:0]                push_start,
  input  logic                         ack,
  output logic [NW-1:0]                cnt,
  output logic [CW-1:0]                head_addr,
  output logic [SW-1:0]                head_done,
  output logic [QDEPTH-1:0][CW-1:0]    ent_start,
  output logic [QDEPTH-1:0]            ent_valid,
  output logic [QDEPTH-1:0][SW-1:0]    ent_done
);

  logic [QDEPTH-1:0][CW-1:0] start_q, start_d;
  logic [QW-1:0] head_q, head_d, tail_q, tail_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] done_q, done_d;
  logic          pop;

  assign pop = ack && (done_q == SW'(NSAMP - 1));

  always_comb begin
    start_d = start_q;
    tail_d  = tail_q;
    head_d  = head_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    if (push) begin
      start_d[tail_q] = push_start;
      tail_d = QW'(idx_add(int'(tail_q), 1, QDEPTH));
    end
    if (ack) begin
      if (pop) begin
        done_d = '0;
        head_d = QW'(idx_add(int'(head_q), 1, QDEPTH));
      end else begin
        done_d = done_q + 1'b1;
      end
    end
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      done_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // Payload needs no reset: entries are qualified by ent_valid
  always_ff @(posedge clk) begin
    if (push) start_q <= start_d;
  end

  assign cnt       = cnt_q;
  assign head_done = done_q;
  assign head_addr = CW'(idx_add(int'(start_q[head_q]), int'(done_q), NCELLS));
  assign ent_start = start_q;

  for (genvar e = 0; e < QDEPTH; e++) begin : g_ent
    assign ent_valid[e] = idx_sub(e, int'(head_q), QDEPTH) < int'(cnt_q);
    assign ent_done[e]  = (QW'(e) == head_q) ? done_q : '0;
  end

endmodule

// File: rtl/pca_reserve_map.sv
module pca_reserve_map
  import pca_pkg::*;
#(
  parameter int NCELLS = 144,
  parameter int QDEPTH = 8,
  parameter int NSAMP  = 5,
  localparam int CW = $clog2(NCELLS),
  localparam int SW = $clog2(NSAMP)
) (
  input  logic [QDEPTH-1:0][CW-1:0] ent_start,
  input  logic [QDEPTH-1:0]         ent_valid,
  input  logic [QDEPTH-1:0][SW-1:0] ent_done,
  input  logic                      pend_en,
  input  logic [CW-1:0]             pend_start,
  output logic [NCELLS-1:0]         res_held,
  output logic [NCELLS-1:0]         res_all
);

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    logic held;
    int   poff;
    always_comb begin
      held = 1'b0;
      for (int e = 0; e < QDEPTH; e++) begin
        int off;
        off = idx_sub(c, int'(ent_start[e]), NCELLS);
        if (ent_valid[e] && off < NSAMP && off >= int'(ent_done[e])) held = 1'b1;
      end
      poff = idx_sub(c, int'(pend_start), NCELLS);
    end
    assign res_held[c] = held;
    assign res_all[c]  = held || (pend_en && poff < NSAMP);
  end

endmodule

// File: rtl/pca_write_search.sv
module pca_write_search
  import pca_pkg::*;
#(
  parameter int NCELLS = 144,
  localparam int CW = $clog2(NCELLS)
) (
  input  logic [CW-1:0]     cur,
  input  logic [NCELLS-1:0] res,
  output logic [CW-1:0]     nxt,
  output logic              found
);

  // Scan from farthest to nearest so the nearest free cell wins
  always_comb begin
    nxt   = cur;
    found = 1'b0;
    for (int k = NCELLS; k >= 1; k--) begin
      int idx;
      idx = idx_add(int'(cur), k, NCELLS);
      if (!res[idx]) begin
        nxt   = CW'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/pipe_cell_addr_ctrl.sv
module pipe_cell_addr_ctrl
  import pca_pkg::*;
#(
  parameter int NCELLS  = 144,
  parameter int MAX_LAT = 100,
  parameter int NSAMP   = 5,
  parameter int QDEPTH  = 8,
  localparam int CW = $clog2(NCELLS),
  localparam int LW = $clog2(MAX_LAT + 1),
  localparam int NW = $clog2(QDEPTH + 1),
  localparam int SW = $clog2(NSAMP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          cfg_we,
  input  logic [LW-1:0] cfg_lat,
  input  logic          rd_req,
  output logic [CW-1:0] wr_addr,
  output logic          wr_en,
  output logic          overflow,
  output logic          rd_valid,
  output logic [CW-1:0] rd_addr,
  output logic          busy,
  output logic          cfg_err
);

  logic [CW-1:0] wr_ptr_q, wr_ptr_d;
  logic          wr_en_q, wr_en_d;
  logic          ovf_q, ovf_d;
  logic [LW-1:0] lat_q, lat_d;
  logic          cerr_q, cerr_d;

  logic [NW-1:0]             pend_cnt;
  logic [SW-1:0]             head_done;
  logic [QDEPTH-1:0][CW-1:0] ent_start;
  logic [QDEPTH-1:0]         ent_valid;
  logic [QDEPTH-1:0][SW-1:0] ent_done;
  logic [NCELLS-1:0]         res_held, res_all;
  logic [CW-1:0]             pend_start, srch_nxt;
  logic                      srch_found, accept, ack, cfg_ok;

  assign busy       = (pend_cnt == NW'(QDEPTH));
  assign rd_valid   = (pend_cnt != '0);
  assign accept     = trig && !busy;
  assign ack        = rd_valid && rd_req;
  assign pend_start = CW'(idx_sub(int'(wr_ptr_q), int'(lat_q), NCELLS));

  pca_event_queue #(.NCELLS(NCELLS), .QDEPTH(QDEPTH), .NSAMP(NSAMP)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (accept),
    .push_start (pend_start),
    .ack        (ack),
    .cnt        (pend_cnt),
    .head_addr  (rd_addr),
    .head_done  (head_done),
    .ent_start  (ent_start),
    .ent_valid  (ent_valid),
    .ent_done   (ent_done)
  );

  pca_reserve_map #(.NCELLS(NCELLS), .QDEPTH(QDEPTH), .NSAMP(NSAMP)) u_map (
    .ent_start  (ent_start),
    .ent_valid  (ent_valid),
    .ent_done   (ent_done),
    .pend_en    (accept),
    .pend_start (pend_start),
    .res_held   (res_held),
    .res_all    (res_all)
  );

  pca_write_search #(.NCELLS(NCELLS)) u_search (
    .cur   (wr_ptr_q),
    .res   (res_all),
    .nxt   (srch_nxt),
    .found (srch_found)
  );

  always_comb begin
    wr_ptr_d = srch_found ? srch_nxt : wr_ptr_q;
    wr_en_d  = srch_found;
    ovf_d    = !srch_found;
    cfg_ok   = cfg_we && (pend_cnt == '0) &&
               (cfg_lat >= LW'(1)) && (cfg_lat <= LW'(MAX_LAT));
    lat_d    = cfg_ok ? cfg_lat : lat_q;
    cerr_d   = cfg_we && !cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= CW'(NCELLS - 1);
      wr_en_q  <= 1'b0;
      ovf_q    <= 1'b0;
      lat_q    <= LW'(MAX_LAT);
      cerr_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      wr_en_q  <= wr_en_d;
      ovf_q    <= ovf_d;
      lat_q    <= lat_d;
      cerr_q   <= cerr_d;
    end
  end

  assign wr_addr  = wr_ptr_q;
  assign wr_en    = wr_en_q;
  assign overflow = ovf_q;
  assign cfg_err  = cerr_q;

endmodule

// File: rtl/pca_checker.sv
module pca_checker
  import pca_pkg::*;
#(
  parameter int NCELLS  = 144,
  parameter int MAX_LAT = 100,
  parameter int NSAMP   = 5,
  parameter int QDEPTH  = 8,
  localparam int CW = $clog2(NCELLS),
  localparam int LW = $clog2(MAX_LAT + 1),
  localparam int NW = $clog2(QDEPTH + 1),
  localparam int SW = $clog2(NSAMP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig,
  input logic              cfg_we,
  input logic              rd_req,
  input logic [CW-1:0]     wr_addr,
  input logic              wr_en,
  input logic              overflow,
  input logic              rd_valid,
  input logic [CW-1:0]     rd_addr,
  input logic              busy,
  input logic              cfg_err,
  input logic [NW-1:0]     pend_cnt,
  input logic [LW-1:0]     lat_q,
  input logic [NCELLS-1:0] res_held,
  input logic [SW-1:0]     head_done
);

  AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !wr_en); // R10

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> wr_addr == $past(wr_addr)); // R10

  AST_WR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !res_held[wr_addr]); // R4

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trig && !(rd_valid && rd_req) |=> pend_cnt == $past(pend_cnt)); // R7

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= NW'(QDEPTH)); // R7

  AST_RD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_req && head_done != SW'(NSAMP - 1)
    |=> rd_addr == CW'(idx_add(int'($past(rd_addr)), 1, NCELLS))); // R5

  AST_CFG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && pend_cnt != '0 |=> cfg_err); // R9

  AST_LAT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt != '0 |=> $stable(lat_q)); // R9

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr < CW'(NCELLS)) && (rd_addr < CW'(NCELLS))); // R8

endmodule

bind pipe_cell_addr_ctrl pca_checker #(
  .NCELLS(NCELLS), .MAX_LAT(MAX_LAT), .NSAMP(NSAMP), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .rd_req(rd_req),
  .wr_addr(wr_addr), .wr_en(wr_en), .overflow(overflow), .rd_valid(rd_valid),
  .rd_addr(rd_addr), .busy(busy), .cfg_err(cfg_err), .pend_cnt(pend_cnt),
  .lat_q(lat_q), .res_held(res_held), .head_done(head_done)
);

// File: tb/tb_pipe_cell_addr_ctrl.sv
module tb_pipe_cell_addr_ctrl;
  localparam int N = 144;

  logic clk = 1'b0;
  logic rst_n, trig, cfg_we, rd_req;
  logic [6:0] cfg_lat;
  logic [7:0] wr_addr, rd_addr;
  logic wr_en, overflow, rd_valid, busy, cfg_err;

  logic s_trig, s_cfg_we, s_rd_req;
  logic [2:0] s_cfg_lat, s_wr_addr, s_rd_addr;
  logic s_wr_en, s_overflow, s_rd_valid, s_busy, s_cfg_err;

  int checks = 0, failures = 0, lat_model = 100;
  int exp_q[$];
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  pipe_cell_addr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
    .rd_req(rd_req), .wr_addr(wr_addr), .wr_en(wr_en), .overflow(overflow),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .busy(busy), .cfg_err(cfg_err));

  pipe_cell_addr_ctrl #(.NCELLS(6), .MAX_LAT(4), .NSAMP(5), .QDEPTH(2)) dut_small (
    .clk(clk), .rst_n(rst_n), .trig(s_trig), .cfg_we(s_cfg_we), .cfg_lat(s_cfg_lat),
    .rd_req(s_rd_req), .wr_addr(s_wr_addr), .wr_en(s_wr_en), .overflow(s_overflow),
    .rd_valid(s_rd_valid), .rd_addr(s_rd_addr), .busy(s_busy), .cfg_err(s_cfg_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; pushes the expected window unless the queue is full
  task automatic do_trig(output int w);
    w = int'(wr_addr);
    if (!busy)
      for (int k = 0; k < 5; k++) exp_q.push_back((w - lat_model + k + 2 * N) % N);
    trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
  endtask

  task automatic do_cfg(input int v, input bit exp_err);
    @(negedge clk);
    cfg_we = 1'b1; cfg_lat = 7'(v);
    @(posedge clk); #1 cfg_we = 1'b0;
    @(negedge clk);
    check(cfg_err == exp_err, "R9 cfg_err", int'(cfg_err), int'(exp_err));
    if (!exp_err) lat_model = v;
  endtask

  task automatic drain();
    @(negedge clk);
    rd_req = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    rd_req = 1'b0;
    #1 check(rd_valid == 1'b0, "R5 rd_valid after drain", int'(rd_valid), 0);
  endtask

  task automatic wait_addr(input int a);
    while (int'(wr_addr) != a) @(negedge clk);
  endtask

  // Scoreboard monitor: compares every acknowledged address with the model
  always @(negedge clk) begin
    #2;
    if (rst_n && rd_valid && rd_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected address", int'(rd_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(rd_addr) == e, "R5 R3 R8 rd_addr", int'(rd_addr), e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, w0, hold;
    rst_n = 1'b0; trig = 1'b0; cfg_we = 1'b0; cfg_lat = '0; rd_req = 1'b0;
    s_trig = 1'b0; s_cfg_we = 1'b0; s_cfg_lat = '0; s_rd_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wr_en && !rd_valid && !busy && !overflow && !cfg_err, "R1 reset outputs",
          int'({wr_en, rd_valid, busy, overflow, cfg_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_addr == 8'd0 && wr_en, "R1 first cell", int'(wr_addr), 0);
    // R2 linear advance
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check(int'(wr_addr) == i && wr_en, "R2 advance", int'(wr_addr), i);
    end

    // R11 default latency, R3 window placement
    do_trig(w);
    @(negedge clk);
    check(rd_valid && int'(rd_addr) == (w - 100 + N) % N, "R11 R3 first offered cell",
          int'(rd_addr), (w - 100 + N) % N);
    drain();

    // R4 skip of cells reserved in the trigger cycle
    do_cfg(2, 1'b0);
    @(negedge clk);
    do_trig(w);
    @(negedge clk);
    check(int'(wr_addr) == (w + 3) % N, "R4 skip", int'(wr_addr), (w + 3) % N);
    do_cfg(50, 1'b1);        // R9 refused while pending
    drain();
    do_cfg(0, 1'b1);         // R9 out of range
    do_cfg(101, 1'b1);       // R9 out of range
    @(negedge clk);
    do_trig(w);              // latency must still be 2
    drain();

    // R8 window straddling the wrap point
    do_cfg(5, 1'b0);
    @(negedge clk);
    wait_addr(2);
    do_trig(w);
    @(negedge clk);
    check(int'(rd_addr) == 141, "R8 wrap start", int'(rd_addr), 141);
    drain();

    // R7 queue full, busy, rejection
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      do_trig(w);
    end
    @(negedge clk);
    check(busy == 1'b1, "R7 busy when full", int'(busy), 1);
    do_trig(w);              // rejected, nothing pushed
    @(negedge clk);
    check(exp_q.size() == 40 && busy, "R7 rejected trigger", exp_q.size(), 40);
    drain();
    check(busy == 1'b0, "R7 busy cleared", int'(busy), 0);

    // R6 release after acknowledgement
    do_cfg(1, 1'b0);
    @(negedge clk);
    do_trig(w);
    @(negedge clk);
    check(int'(wr_addr) == (w + 4) % N, "R4 skip forward window", int'(wr_addr), (w + 4) % N);
    wait_addr((w - 2 + N) % N);
    @(negedge clk);
    check(int'(wr_addr) == (w + 4) % N, "R6 held cells still skipped", int'(wr_addr), (w + 4) % N);
    drain();
    wait_addr((w - 2 + N) % N);
    @(negedge clk);
    check(int'(wr_addr) == (w - 1 + N) % N, "R6 released cell reused", int'(wr_addr), (w - 1 + N) % N);

    // R10 overflow on a 6-cell ring with two 5-cell windows
    @(negedge clk);
    s_cfg_we = 1'b1; s_cfg_lat = 3'd1;
    @(posedge clk); #1 s_cfg_we = 1'b0;
    @(negedge clk);
    w0 = int'(s_wr_addr);
    s_trig = 1'b1;
    @(posedge clk); #1 s_trig = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(s_wr_addr) == (w0 + 4) % 6 && s_wr_en, "R4 small ring single free cell",
          int'(s_wr_addr), (w0 + 4) % 6);
    s_trig = 1'b1;
    @(posedge clk); #1 s_trig = 1'b0;
    @(negedge clk);
    check(s_overflow && !s_wr_en, "R10 overflow drops sample",
          int'({s_overflow, s_wr_en}), 2);
    check(s_busy == 1'b1, "R7 small busy", int'(s_busy), 1);
    hold = int'(s_wr_addr);
    @(negedge clk);
    check(int'(s_wr_addr) == hold && s_overflow, "R10 pointer holds", int'(s_wr_addr), hold);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule